// File: doc/BRIEF.md
# Integer Minimum/Maximum Unit

This unit returns the smaller or the larger of two 64-bit integer operands. A 3-bit mode code picks whether the comparison uses the whole doubleword or only the low 32-bit word, whether the operands are treated as signed or unsigned, and whether the minimum or the maximum is wanted. All eight combinations share one unsigned magnitude comparator. Word mode moves each operand's low word into the upper half and zero-fills the lower half. Signed mode inverts the top bit of each comparison key, which turns signed order into unsigned order.

The value returned is always the full, untransformed 64-bit source that won, even when only the low words were compared. When the instruction's first source index is zero, operand A is the constant zero. With the record bit set, the unit also produces a 4-bit condition field. Its upper three bits give the A-versus-B relation as seen by the selected comparison, independent of min or max. Its low bit copies the summary-overflow input. A write strobe marks when that field is to be written. A parameter places an optional register stage on all outputs.

Top module: `int_minmax_unit`

## Requirements
- R1: mode_i bit 2 selects word comparison (set) or doubleword comparison (clear), bit 1 selects signed (set) or unsigned (clear), and bit 0 selects maximum (set) or minimum (clear).
- R2: In word mode only bits 31:0 of each operand affect the comparison; bits 63:32 are ignored for ordering.
- R3: In signed mode the operands are ordered as two's complement numbers of the compared width; in unsigned mode they are ordered as plain binary.
- R4: result_o is always the complete 64-bit original operand that was chosen, including its upper half in word mode.
- R5: When a_zero_i is set, operand A is taken as zero for both comparison and result, whatever a_i holds.
- R6: When rec_i is set, cr_o[3:1] is 100 when A<B, 010 when A>B and 001 when they are equal, using the selected width and signedness. The code is the same for min and max. cr_o[0] equals so_i.
- R7: cr_we_o is high only for a valid operation with rec_i set; otherwise cr_we_o and cr_o are zero.
- R8: Minimum returns A only when A<B and maximum returns A only when A>B; when the compared values are equal, B is returned.
- R9: With the default output register, results, flags and valid_o appear one clock after valid_i; after reset, valid_o, result_o, cr_o and cr_we_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| mode_i | input | 3 | {word, signed, max} mode code |
| a_zero_i | input | 1 | Replace operand A with zero |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| rec_i | input | 1 | Record bit: produce condition field |
| so_i | input | 1 | Summary-overflow bit to append |
| valid_o | output | 1 | Result present |
| result_o | output | 64 | Selected original operand |
| cr_o | output | 4 | Condition field {lt, gt, eq, so} |
| cr_we_o | output | 1 | Condition field write strobe |

## Verification
A fault in the word shift or the sign inversion shows up as a wrong winner on the very next valid output. The first symptoms appear for operands near the sign boundary (0x8000... against 0x7FFF...) or with equal low words but different upper halves. A fault in tie handling or in the max swap shows up when the relation field reads equal but the result is not B, or when the relation code changes between the min and max variants of one pair. Since the unit holds no state beyond the output stage, every error appears within one clock of the operation that caused it.

// File: rtl/minmax_pkg.sv
package minmax_pkg;

  typedef struct packed {
    logic word;
    logic sgn;
    logic mx;
  } mm_mode_t;

  // relation code, bit order is what the condition field consumer decodes
  typedef enum logic [2:0] {
    REL_LT = 3'b100,
    REL_GT = 3'b010,
    REL_EQ = 3'b001
  } mm_rel_e;

  function automatic mm_mode_t mm_decode(input logic [2:0] code);
    mm_mode_t m;
    m.word = code[2];
    m.sgn  = code[1];
    m.mx   = code[0];
    return m;
  endfunction

endpackage

// File: rtl/mm_operand_xform.sv
module mm_operand_xform #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] op_i,
  input  logic            word_i,
  input  logic            sgn_i,
  output logic [XLEN-1:0] key_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] placed;

  always_comb begin
    placed = word_i ? {op_i[HALF-1:0], {HALF{1'b0}}} : op_i;
    key_o  = {placed[XLEN-1] ^ sgn_i, placed[XLEN-2:0]};
  end

endmodule

// File: rtl/mm_compare.sv
module mm_compare #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned CHUNK = 16
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output minmax_pkg::mm_rel_e rel_o
);
  import minmax_pkg::*;

  localparam int unsigned NCH = XLEN / CHUNK;

  logic [NCH-1:0] ch_lt, ch_eq;

  // per-chunk compare, then priority from the most significant chunk
  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign ch_lt[g] = a_i[g*CHUNK +: CHUNK] <  b_i[g*CHUNK +: CHUNK];
    assign ch_eq[g] = a_i[g*CHUNK +: CHUNK] == b_i[g*CHUNK +: CHUNK];
  end

  logic lt, eq;

  always_comb begin
    lt = 1'b0;
    eq = 1'b1;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eq) begin
        lt = ch_lt[i];
        eq = ch_eq[i];
      end
    end
    if (eq)      rel_o = REL_EQ;
    else if (lt) rel_o = REL_LT;
    else         rel_o = REL_GT;
  end

endmodule

// File: rtl/mm_select.sv
module mm_select #(
  parameter int unsigned XLEN = 64
) (
  input  minmax_pkg::mm_rel_e rel_i,
  input  logic                mx_i,
  input  logic [XLEN-1:0]     a_i,
  input  logic [XLEN-1:0]     b_i,
  output logic [XLEN-1:0]     res_o
);
  import minmax_pkg::*;

  logic take_a;

  // max swaps the operands, so only a strict win selects A
  always_comb begin
    take_a = mx_i ? (rel_i == REL_GT) : (rel_i == REL_LT);
    res_o  = take_a ? a_i : b_i;
  end

endmodule

// File: rtl/int_minmax_unit.sv
module int_minmax_unit #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CHUNK   = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      mode_i,
  input  logic            a_zero_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            rec_i,
  input  logic            so_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic [3:0]      cr_o,
  output logic            cr_we_o
);
  import minmax_pkg::*;

  mm_mode_t        mode;
  logic [XLEN-1:0] a_eff;
  logic [XLEN-1:0] a_key, b_key;
  mm_rel_e         rel;
  logic [XLEN-1:0] res_d;
  logic [3:0]      cr_d;
  logic            we_d;

  assign mode  = mm_decode(mode_i);
  assign a_eff = a_zero_i ? '0 : a_i;

  mm_operand_xform #(.XLEN(XLEN)) i_xform_a (
    .op_i(a_eff), .word_i(mode.word), .sgn_i(mode.sgn), .key_o(a_key)
  );

  mm_operand_xform #(.XLEN(XLEN)) i_xform_b (
    .op_i(b_i), .word_i(mode.word), .sgn_i(mode.sgn), .key_o(b_key)
  );

  mm_compare #(.XLEN(XLEN), .CHUNK(CHUNK)) i_cmp (
    .a_i(a_key), .b_i(b_key), .rel_o(rel)
  );

  mm_select #(.XLEN(XLEN)) i_sel (
    .rel_i(rel), .mx_i(mode.mx), .a_i(a_eff), .b_i(b_i), .res_o(res_d)
  );

  // flags follow A-vs-B order, taken before any max swap
  assign we_d = valid_i & rec_i;
  assign cr_d = we_d ? {rel, so_i} : 4'b0000;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o  <= 1'b0;
        result_o <= '0;
        cr_o     <= '0;
        cr_we_o  <= 1'b0;
      end else begin
        valid_o  <= valid_i;
        result_o <= valid_i ? res_d : '0;
        cr_o     <= cr_d;
        cr_we_o  <= we_d;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o    = valid_i;
    assign result_o   = valid_i ? res_d : '0;
    assign cr_o       = cr_d;
    assign cr_we_o    = we_d;
  end

endmodule

// File: rtl/int_minmax_unit_chk.sv
module int_minmax_unit_chk #(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            a_zero_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic            rec_i,
  input logic            so_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic [3:0]      cr_o,
  input logic            cr_we_o
);
  if (REG_OUT) begin : g_chk
    AST_WE_NEEDS_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cr_we_o |-> $past(valid_i && rec_i)); // R7
    AST_NO_FLAGS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cr_we_o |-> (cr_o == 4'b0000)); // R7
    AST_REL_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cr_we_o |-> ($countones(cr_o[3:1]) == 1)); // R6
    AST_SO_COPIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cr_we_o |-> (cr_o[0] == $past(so_i))); // R6
    AST_RESULT_IS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ((result_o == $past(b_i)) ||
                   (result_o == ($past(a_zero_i) ? '0 : $past(a_i))))); // R4
    AST_TIE_GIVES_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && cr_we_o && cr_o[3:1] == 3'b001) |-> (result_o == $past(b_i))); // R8
  end
endmodule

bind int_minmax_unit int_minmax_unit_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_zero_i(a_zero_i),
  .a_i(a_i), .b_i(b_i), .rec_i(rec_i), .so_i(so_i), .valid_o(valid_o),
  .result_o(result_o), .cr_o(cr_o), .cr_we_o(cr_we_o)
);

// File: tb/test_int_minmax_unit.sv
module test_int_minmax_unit;

  typedef struct {
    logic [63:0] res;
    logic [3:0]  cr;
    logic        we;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        a_zero_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        rec_i = 1'b0, so_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [3:0]  cr_o;
  logic        cr_we_o;

  int n_cmp = 0, n_bad = 0;
  exp_t q[$];
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  int_minmax_unit i_int_minmax_unit (
    .clk_i, .rst_ni, .valid_i, .mode_i, .a_zero_i, .a_i, .b_i,
    .rec_i, .so_i, .valid_o, .result_o, .cr_o, .cr_we_o
  );

  task automatic check64(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // reference model straight from the requirements
  function automatic exp_t model(logic [2:0] m, logic az, logic [63:0] a,
                                 logic [63:0] b, logic rec, logic so, string tag);
    exp_t e;
    logic lt, gt;
    logic [63:0] av;
    av = az ? 64'd0 : a;
    if (m[2]) begin
      if (m[1]) begin
        lt = $signed(av[31:0]) < $signed(b[31:0]);
        gt = $signed(av[31:0]) > $signed(b[31:0]);
      end else begin
        lt = av[31:0] < b[31:0];
        gt = av[31:0] > b[31:0];
      end
    end else begin
      if (m[1]) begin
        lt = $signed(av) < $signed(b);
        gt = $signed(av) > $signed(b);
      end else begin
        lt = av < b;
        gt = av > b;
      end
    end
    e.res = m[0] ? (gt ? av : b) : (lt ? av : b);
    e.cr  = rec ? {lt, gt, !lt && !gt, so} : 4'b0000;
    e.we  = rec;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [2:0] m, logic az, logic [63:0] a, logic [63:0] b,
                       logic rec, logic so, string tag);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = m; a_zero_i = az; a_i = a; b_i = b;
    rec_i = rec; so_i = so;
    q.push_back(model(m, az, a, b, rec, so, tag));
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0; rec_i = 1'b0;
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          check64("R9", "unexpected valid_o", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check64(e.tag, "result", result_o, e.res);
          check64(e.tag, "cr", {60'd0, cr_o}, {60'd0, e.cr});
          check64("R7", "cr_we", {63'd0, cr_we_o}, {63'd0, e.we});
        end
      end else begin
        check64("R7", "idle cr_we", {63'd0, cr_we_o}, 64'd0);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXS = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check64("R9", "reset valid_o", {63'd0, valid_o}, 64'd0);
    check64("R9", "reset result", result_o, 64'd0);
    check64("R9", "reset cr", {60'd0, cr_o}, 64'd0);
    check64("R9", "reset cr_we", {63'd0, cr_we_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int m = 0; m < 8; m++) begin
      logic [2:0] md;
      md = 3'(m);
      // R1 R3: sign boundary under every mode
      drive(md, 1'b0, MINS, MAXS, 1'b1, m[0], "R3");
      drive(md, 1'b0, ONES, 64'd0, 1'b1, 1'b0, "R3");
      drive(md, 1'b0, 64'd5, ONES - 64'd2, 1'b1, 1'b1, "R1");
      // R8 ties, different upper halves in word mode
      drive(md, 1'b0, 64'h1234_5678_0000_0005, 64'hABCD_0000_0000_0005, 1'b1, 1'b0,
            md[2] ? "R8" : "R2");
      drive(md, 1'b0, ONES, ONES, 1'b1, 1'b1, "R8");
      // R2 R4: word sign boundary, upper halves differ the other way
      drive(md, 1'b0, 64'h0000_0001_8000_0000, 64'hFFFF_0000_7FFF_FFFF, 1'b1, 1'b0, "R4");
      drive(md, 1'b0, 64'hDEAD_BEEF_0000_0003, 64'h0000_0000_0000_0009, 1'b1, 1'b0, "R2");
      // R5 zero substitution
      drive(md, 1'b1, 64'h0000_0000_0000_0042, 64'h0000_0000_0000_0007, 1'b1, 1'b0, "R5");
      drive(md, 1'b1, ONES, MINS | 64'd1, 1'b1, 1'b1, "R5");
      // R7 no record
      drive(md, 1'b0, MAXS, MINS, 1'b0, 1'b1, "R7");
      // R6 relation must not depend on min/max: same pair, flags checked by model
      drive(md, 1'b0, 64'd3, 64'd4, 1'b1, 1'b1, "R6");
      idle();
    end
    idle();
    idle();
    check64("R9", "queue drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule